// File: doc/BRIEF.md
# Core Timer with Selectable Periodic Interrupt

This block is a free-running time base for a small microcontroller. Each cycle in which the bus clock enable is high advances one 15-stage binary chain. The lowest two stages act as a divide-by-4 prescaler. The next eight stages form the 8-bit timer counter, and its wrap from 0xFF to 0x00 raises a sticky overflow flag. The top four stages are tap points for a periodic event, and a 2-bit rate field picks which tap sets a second sticky flag.

Software uses one 8-bit register on a plain read/write port. A read shows the two flags, the two interrupt enables and the rate field. A write updates the enables and the rate. Bits 7 and 6 of a write are clear strobes: a 1 in either clears the matching flag. A single interrupt request output is high while an enabled flag is set.

Top module: `core_timer`

## Requirements
- R1: After reset the register reads 0x03 and `irq` is low: both flags and both enables are 0, and the rate field is 11.
- R2: The read layout is bit 7 overflow flag, bit 6 periodic flag, bit 5 overflow enable, bit 4 periodic enable, bits 3:2 always 0, bits 1:0 rate. A write stores bits 5, 4, 1 and 0. Write bits 3:2 are ignored.
- R3: The chain advances only on `bus_en`. The overflow flag sets on the enable that wraps the counter, which is the 1024th enable after the chain is zero and every 1024th enable after that.
- R4: Rate r (0 to 3) selects divide by 2^(12+r). The periodic flag sets on the enable that makes chain bit 11+r rise, which is enable number 2^(11+r) after the chain is zero and then every 2^(12+r) enables.
- R5: Writing 1 to bit 7 clears the overflow flag, and writing 1 to bit 6 clears the periodic flag. Writing 0 to either bit leaves its flag unchanged. No write can set a flag.
- R6: `irq` = (overflow flag AND overflow enable) OR (periodic flag AND periodic enable).
- R7: If a flag's set event and a clear write fall in the same cycle, the flag ends up set.
- R8: A write to the rate field takes effect at once and does not reset the chain.
- R9: Cycles with `bus_en` low do not advance the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_en | input | 1 | Bus clock enable; advances the chain |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Register read value |
| irq | output | 1 | Combined interrupt request |

## Verification
Two functions can land on the same clock edge: a flag's set event from the divider chain and a software write that clears that flag. The bench steps the chain with counted enables until it is one enable short of a counter wrap. It then issues the clear-overflow write in the same cycle as the final enable. The check passes only if the overflow flag reads as set afterwards. Clears issued in cycles with no event must still take effect, which rules out a design that simply ignores writes.

// File: rtl/ct_pkg.sv
// Shared sizing for the core timer. The chain is the prescaler, then the
// 8-bit counter, then extra stages up to the highest periodic tap.
package ct_pkg;
    localparam int PRE_W     = 2;   // prescaler stages (divide by 4)
    localparam int CNT_W     = 8;   // visible timer counter stages
    localparam int NUM_TAPS  = 4;   // selectable periodic taps
    localparam int TAP_BASE  = 11;  // chain bit of the fastest tap (2^12 period)
    localparam int REG_W     = 8;   // register width

    // Register bit positions that software decodes
    localparam int B_OVF_F  = 7;
    localparam int B_PER_F  = 6;
    localparam int B_OVF_E  = 5;
    localparam int B_PER_E  = 4;
endpackage

// File: rtl/ct_divider.sv
// Free-running binary chain advanced by the bus clock enable.
// Assumes TAP_BASE >= PRE_W + CNT_W. Each event output is a one-cycle
// lookahead of a carry, so it is high in the cycle whose enable causes it.
module ct_divider #(
    parameter int PRE_W    = 2,
    parameter int CNT_W    = 8,
    parameter int TAP_BASE = 11,
    parameter int NUM_TAPS = 4,
    localparam int CHAIN_W = TAP_BASE + NUM_TAPS,
    localparam int WRAP_W  = PRE_W + CNT_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    output logic [CHAIN_W-1:0]  chain,
    output logic                wrap_evt,
    output logic [NUM_TAPS-1:0] tap_rise
);

    // Purpose: advance the whole chain by one on each enabled cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            chain <= '0;
        else if (tick)
            chain <= chain + 1'b1;
    end

    // Purpose: the counter wraps when prescaler and counter are all ones.
    always_comb begin
        wrap_evt = tick && (&chain[WRAP_W-1:0]);
    end

    // Purpose: one rising-edge lookahead per periodic tap.
    generate
        for (genvar t = 0; t < NUM_TAPS; t++) begin : g_tap
            always_comb begin
                tap_rise[t] = tick && (&chain[TAP_BASE+t-1:0]) && !chain[TAP_BASE+t];
            end
        end
    endgenerate

endmodule

// File: rtl/ct_tap_sel.sv
// Selects the periodic event from the tap chosen by the rate field.
// Since each tap has its own edge detect, a rate change alone makes no event.
module ct_tap_sel #(
    parameter int NUM_TAPS = 4,
    localparam int RATE_W  = $clog2(NUM_TAPS)
) (
    input  logic [NUM_TAPS-1:0] tap_rise,
    input  logic [RATE_W-1:0]   rate,
    output logic                per_evt
);

    // Purpose: route the selected tap's rise to the periodic flag.
    always_comb begin
        per_evt = tap_rise[rate];
    end

endmodule

// File: rtl/ct_regs.sv
// Control/status register: sticky flags, enables, rate field, interrupt.
// Assumes the event inputs are single-cycle pulses. A set beats a clear.
module ct_regs #(
    parameter int REG_W    = 8,
    parameter int RATE_W   = 2,
    parameter int B_OVF_F  = 7,
    parameter int B_PER_F  = 6,
    parameter int B_OVF_E  = 5,
    parameter int B_PER_E  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              ovf_evt,
    input  logic              per_evt,
    output logic [REG_W-1:0]  rd_data,
    output logic [RATE_W-1:0] rate,
    output logic              irq
);

    logic ovf_f, per_f, ovf_e, per_e;
    logic clr_ovf, clr_per;

    // Purpose: decode the write-only clear strobes.
    always_comb begin
        clr_ovf = wr_en && wr_data[B_OVF_F];
        clr_per = wr_en && wr_data[B_PER_F];
    end

    // Purpose: sticky flags; the set term wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_f <= 1'b0;
            per_f <= 1'b0;
        end else begin
            ovf_f <= ovf_evt || (ovf_f && !clr_ovf);
            per_f <= per_evt || (per_f && !clr_per);
        end
    end

    // Purpose: software-writable enables and rate field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_e <= 1'b0;
            per_e <= 1'b0;
            rate  <= '1;
        end else if (wr_en) begin
            ovf_e <= wr_data[B_OVF_E];
            per_e <= wr_data[B_PER_E];
            rate  <= wr_data[RATE_W-1:0];
        end
    end

    // Purpose: assemble the read view; unused bits read zero.
    always_comb begin
        rd_data             = '0;
        rd_data[B_OVF_F]    = ovf_f;
        rd_data[B_PER_F]    = per_f;
        rd_data[B_OVF_E]    = ovf_e;
        rd_data[B_PER_E]    = per_e;
        rd_data[RATE_W-1:0] = rate;
    end

    // Purpose: combined interrupt request.
    always_comb begin
        irq = (ovf_f && ovf_e) || (per_f && per_e);
    end

endmodule

// File: rtl/core_timer.sv
// Core timer top: divider chain, periodic tap select and control register.
// Assumes one register port with a single-cycle write strobe and a
// combinational read.
module core_timer
    import ct_pkg::*;
#(
    parameter int P_PRE_W    = PRE_W,
    parameter int P_CNT_W    = CNT_W,
    parameter int P_TAP_BASE = TAP_BASE,
    parameter int P_NUM_TAPS = NUM_TAPS,
    localparam int CHAIN_W   = P_TAP_BASE + P_NUM_TAPS,
    localparam int RATE_W    = $clog2(P_NUM_TAPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_en,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    output logic             irq
);

    logic [CHAIN_W-1:0]    chain;
    logic                  ovf_evt;
    logic                  per_evt;
    logic [P_NUM_TAPS-1:0] tap_rise;
    logic [RATE_W-1:0]     rate;

    ct_divider #(
        .PRE_W(P_PRE_W), .CNT_W(P_CNT_W),
        .TAP_BASE(P_TAP_BASE), .NUM_TAPS(P_NUM_TAPS)
    ) u_div (
        .clk(clk), .rst_n(rst_n), .tick(bus_en),
        .chain(chain), .wrap_evt(ovf_evt), .tap_rise(tap_rise)
    );

    ct_tap_sel #(.NUM_TAPS(P_NUM_TAPS)) u_sel (
        .tap_rise(tap_rise), .rate(rate), .per_evt(per_evt)
    );

    ct_regs #(
        .REG_W(REG_W), .RATE_W(RATE_W),
        .B_OVF_F(B_OVF_F), .B_PER_F(B_PER_F),
        .B_OVF_E(B_OVF_E), .B_PER_E(B_PER_E)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .ovf_evt(ovf_evt), .per_evt(per_evt),
        .rd_data(rd_data), .rate(rate), .irq(irq)
    );

endmodule

// File: rtl/ct_checker.sv
// Temporal checks on the core timer, attached by bind.
module ct_checker #(
    parameter int CHAIN_W = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_en,
    input logic               wr_en,
    input logic [7:0]         wr_data,
    input logic [7:0]         rd_data,
    input logic               irq,
    input logic               ovf_evt,
    input logic               per_evt,
    input logic [CHAIN_W-1:0] chain
);

    p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_evt |=> rd_data[7]);

    p_per_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        per_evt |=> rd_data[6]);

    p_ovf_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[7] && !ovf_evt) |=> !rd_data[7]);

    p_ovf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_evt && !(wr_en && wr_data[7])) |=> $stable(rd_data[7]));

    p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (per_evt && wr_en && wr_data[6]) |=> rd_data[6]);

    p_irq_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq == ((rd_data[7] && rd_data[5]) || (rd_data[6] && rd_data[4])));

    p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> $stable(chain));

    p_rate_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !bus_en) |=> $stable(chain));

endmodule

bind core_timer ct_checker #(.CHAIN_W(CHAIN_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .wr_en(wr_en),
    .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
    .ovf_evt(ovf_evt), .per_evt(per_evt), .chain(chain)
);

// File: tb/sim_core_timer.sv
`timescale 1ns/1ps
module sim_core_timer;

    typedef struct {
        logic [7:0] rd;
        logic       irq;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    item_t exp_q[$];

    always #4 clk = ~clk;   // 125 MHz

    core_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    // Monitor: compare queued expectations against the ports
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            checks++;
            if (rd_data !== it.rd || irq !== it.irq) begin
                errors++;
                $display("FAIL %s: rd=%h irq=%b expected rd=%h irq=%b",
                         it.tag, rd_data, irq, it.rd, it.irq);
            end
        end
    end

    // Driver: push an expectation, let the monitor take it
    task automatic expect_reg(input logic [7:0] rd, input logic i, input string tag);
        item_t it;
        it.rd = rd; it.irq = i; it.tag = tag;
        exp_q.push_back(it);
        repeat (2) @(negedge clk);
    endtask

    task automatic write_reg(input logic [7:0] d, input logic en);
        wr_en = 1'b1; wr_data = d; bus_en = en;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00; bus_en = 1'b0;
    endtask

    task automatic pulse(input int k);
        bus_en = 1'b1;
        repeat (k) @(negedge clk);
        bus_en = 1'b0;
    endtask

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung, expected completion");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_reg(8'h03, 1'b0, "R1 reset value");

        write_reg(8'h3C, 1'b0);
        expect_reg(8'h30, 1'b0, "R2 bits 3:2 ignored, enables stored");
        write_reg(8'h00, 1'b0);
        expect_reg(8'h00, 1'b0, "R2 rate 00 stored");

        pulse(1023);                                   // n = 1023
        expect_reg(8'h00, 1'b0, "R3 no wrap before 1024");
        pulse(1);                                      // n = 1024
        expect_reg(8'h80, 1'b0, "R3 overflow at wrap, R6 masked");
        write_reg(8'h20, 1'b0);
        expect_reg(8'hA0, 1'b1, "R6 overflow irq");
        write_reg(8'hA0, 1'b0);
        expect_reg(8'h20, 1'b0, "R5 clear overflow");

        pulse(1024);                                   // n = 2048
        expect_reg(8'hE0, 1'b1, "R4 rate 0 first event at 2048");
        write_reg(8'h60, 1'b0);
        expect_reg(8'hA0, 1'b1, "R5 clear periodic only");
        write_reg(8'h00, 1'b0);
        expect_reg(8'h80, 1'b0, "R5 zero in bit 7 no effect");

        write_reg(8'h01, 1'b0);
        expect_reg(8'h81, 1'b0, "R8 rate write, no event");
        pulse(2048);                                   // n = 4096
        expect_reg(8'hC1, 1'b0, "R8 rate 1 event, chain not reset");

        write_reg(8'hC0, 1'b0);
        expect_reg(8'h00, 1'b0, "R5 clear both");
        write_reg(8'hC0, 1'b0);
        expect_reg(8'h00, 1'b0, "R5 write cannot set flags");

        pulse(1023);                                   // n = 5119
        expect_reg(8'h00, 1'b0, "R3 one short of wrap");
        write_reg(8'h80, 1'b1);                        // n = 5120, clear with set
        expect_reg(8'h80, 1'b0, "R7 set wins over clear");

        write_reg(8'h90, 1'b0);
        expect_reg(8'h10, 1'b0, "R5 clear with periodic enable");
        pulse(1024);                                   // n = 6144
        expect_reg(8'hD0, 1'b1, "R4 rate 0 period 4096, R6 periodic irq");
        write_reg(8'h50, 1'b0);
        expect_reg(8'h90, 1'b0, "R6 irq drops with periodic cleared");

        write_reg(8'hC0, 1'b0);
        repeat (200) @(negedge clk);                   // idle, no enables
        pulse(1023);                                   // n = 7167
        expect_reg(8'h00, 1'b0, "R9 idle cycles do not advance");
        pulse(1);                                      // n = 7168
        expect_reg(8'h80, 1'b0, "R9 wrap after counted enables");

        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        expect_reg(8'h03, 1'b0, "R1 value after second reset");
        pulse(16383);
        expect_reg(8'h83, 1'b0, "R4 rate 3 no event before 16384");
        pulse(1);
        expect_reg(8'hC3, 1'b0, "R1 R4 reset rate gives 2^15 divide");

        done = 1'b1;
        summary();
    end

endmodule